// File: doc/BRIEF.md
# SMBus Target Transaction Engine with Optional Packet Error Checking

This block is the byte-level transaction layer of a power-management bus target. A bit-level front end handles the pads, clock stretching and shifting. It hands this engine one-cycle events: START (including repeated START), STOP, each byte received from the controller, and each byte it has finished sending. The engine decides whether to acknowledge each received byte and supplies the next byte to transmit. It buffers write transactions and commits them to the register interface only at STOP.

Packet error checking is inferred, not configured per transaction. A write is complete once it has carried its command and, for commands that take one, a data byte. If STOP comes next, the write had no PEC. If one more byte is clocked in first, that byte is checked against a CRC-8 kept over every byte of the transaction. A configuration input can make PEC mandatory for writes. The engine also drives the alert line and answers the alert response address with its own address. After answering, it drops the alert for one cycle. It then raises the alert again if a persistent external fault is still present. The internal communication fault never re-raises the alert in this way.

The state machine has these states:

- ST_IDLE: no transaction.
- ST_ADDR: waiting for the address byte.
- ST_CMD: waiting for the command code.
- ST_DATA: waiting for the data byte.
- ST_PEC: payload complete; a PEC byte may follow.
- ST_CHK: PEC received; any further byte is an error.
- ST_RD: sending the status byte.
- ST_ARA: sending its own address for the alert response.
- ST_RPEC: sending the PEC of a read.
- ST_SKIP: not addressed, or finished; ignoring the bus.

Transitions:

- Any state goes to ST_ADDR on START and to ST_IDLE on STOP.
- ST_ADDR goes to ST_CMD on an own write address, to ST_RD on an own read address, to ST_ARA on the alert response read while alerting, and to ST_SKIP otherwise.
- ST_CMD goes to ST_PEC for a send-byte command and to ST_DATA for any other command.
- ST_DATA goes to ST_PEC on a byte.
- ST_PEC goes to ST_CHK on a byte.
- ST_RD goes to ST_RPEC when its byte is sent.
- ST_ARA goes to ST_RPEC when its byte is sent, or to ST_SKIP when arbitration is lost.
- ST_RPEC goes to ST_SKIP when its byte is sent.

Top module: `smbus_pec_target`

## Requirements
- R1: The byte after START is acknowledged when its upper seven bits equal `own_addr`, in either direction. It is also acknowledged when it equals 0x19 (alert response address 0x0C, read) while `alert` is high. Any other address byte is not acknowledged, and neither is any later byte until the next START. `ack` and `ack_vld` are valid in the cycle after `rx_valid`.
- R2: In a write, a STOP that arrives right after the payload marks the write as having no PEC. Such a write is committed when `cfg_pec_req` is low. The payload is the command, plus one data byte unless the command is a send-byte command (0x03 or 0x15).
- R3: The PEC is CRC-8, polynomial 0x07, initial value 0, MSB first. It covers every byte since START, including the address byte. A write whose extra byte equals this CRC is committed at STOP.
- R4: A write whose PEC byte mismatches, or that has further bytes after its PEC, is discarded. It sets the communication fault (status bit 0) and asserts `alert`. Bytes after the PEC are not acknowledged.
- R5: With `cfg_pec_req` high, a write that reaches STOP without a PEC is discarded and sets the communication fault.
- R6: `wr_stb` pulses for one cycle, the cycle after STOP, carrying `wr_cmd` and `wr_data` (0 for send-byte commands). A write cut short by STOP or by a repeated START commits nothing and sets no fault.
- R7: Committing command 0x15 pulses `store_req` together with `wr_stb`. Committing command 0x03 clears the communication fault.
- R8: A read to `own_addr` returns a status byte and then its PEC. In the status byte, bit 0 is the communication fault, bits NFLT:1 are `fault_in`, and the upper bits are 0. The byte values are captured when the address is acknowledged.
- R9: An alert response returns {`own_addr`,0} followed by its PEC. When that byte completes without lost arbitration, `alert` is low in the next cycle.
- R10: One cycle after the release, `alert` rises again if any `fault_in` bit is set. A pending communication fault alone does not raise it again.
- R11: If arbitration is lost during the alert response byte, `alert` stays high and the engine sends only 0xFF until the next START.
- R12: `alert` is set when the communication fault is set and when any `fault_in` bit rises. It stays set until an alert response completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Target bus address |
| cfg_pec_req | input | 1 | Reject writes without PEC |
| fault_in | input | NFLT | Persistent faults, one per status group |
| ev_start | input | 1 | START or repeated START event |
| ev_stop | input | 1 | STOP event |
| rx_valid | input | 1 | A byte was received |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | The current transmit byte was sent |
| arb_lost | input | 1 | Arbitration lost during the sent byte |
| ack | output | 1 | Acknowledge decision for the last received byte |
| ack_vld | output | 1 | `ack` is valid |
| tx_byte | output | 8 | Next byte to send |
| wr_stb | output | 1 | Commit strobe |
| wr_cmd | output | 8 | Committed command code |
| wr_data | output | 8 | Committed data byte |
| store_req | output | 1 | Request to store settings as defaults |
| alert | output | 1 | Alert line, active high |

## Verification
The hardest behaviour to reach is the release and re-raise around an alert response. It needs an alert that is already pending, then a completed response byte, then a check two cycles in a row. Whether the alert comes back depends on which fault caused it. The bench reaches this with directed sequences. First it makes a bad-PEC write, so only the communication fault is pending, and runs a response. Then it raises an external fault and runs a response again, and once more with arbitration lost. Randomized writes mix the four PEC cases with the mandatory-PEC option, and a bench model of the CRC predicts each commit or reject.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_PEC,
        ST_CHK,
        ST_RD,
        ST_ARA,
        ST_RPEC,
        ST_SKIP
    } smbt_state_e;

    localparam logic [6:0] ARA_ADDR = 7'h0C;

    // One byte of CRC-8, polynomial 0x07, byte-wise fold
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int i = 0; i < 8; i++) begin
            x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/smbt_pec_acc.sv
module smbt_pec_acc
    import smbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 8'h00;
        end else if (clr) begin
            crc <= 8'h00;
        end else if (en) begin
            crc <= crc8_step(crc, din);
        end
    end
endmodule

// File: rtl/smbt_addr_dec.sv
module smbt_addr_dec
    import smbt_pkg::*;
(
    input  logic [7:0] addr_byte,
    input  logic [6:0] own_addr,
    input  logic       alert,
    output logic       own_w,
    output logic       own_r,
    output logic       ara_r
);
    logic match;
    always_comb begin
        match = (addr_byte[7:1] == own_addr);
        own_w = match && !addr_byte[0];
        own_r = match && addr_byte[0];
        ara_r = (addr_byte == {ARA_ADDR, 1'b1}) && alert && !match;
    end
endmodule

// File: rtl/smbt_alert_ctrl.sv
module smbt_alert_ctrl #(
    parameter int NFLT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLT-1:0] fault_in,
    input  logic            cml_set,
    input  logic            cml_clr,
    input  logic            ara_done,
    output logic            alert,
    output logic            cml
);
    logic [NFLT-1:0] fault_q;
    logic            rearm;
    logic            rise;

    always_comb rise = |(fault_in & ~fault_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= '0;
            rearm   <= 1'b0;
            cml     <= 1'b0;
            alert   <= 1'b0;
        end else begin
            fault_q <= fault_in;
            rearm   <= ara_done;
            if (cml_set) begin
                cml <= 1'b1;
            end else if (cml_clr) begin
                cml <= 1'b0;
            end
            if (ara_done) begin
                alert <= 1'b0;
            end else if (rearm) begin
                alert <= (|fault_in) | cml_set | rise;
            end else if (cml_set || rise) begin
                alert <= 1'b1;
            end
        end
    end

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ara_done |=> !alert);

    p_reassert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ara_done) && !ara_done && (|fault_in)) |=> alert);

    p_cml_alert_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cml_set && !ara_done) |=> (alert && cml));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (alert && !ara_done) |=> alert);
endmodule

// File: rtl/smbus_pec_target.sv
module smbus_pec_target
    import smbt_pkg::*;
#(
    parameter int          NFLT      = 4,
    parameter logic [7:0]  STORE_CMD = 8'h15,
    parameter logic [7:0]  CLR_CMD   = 8'h03
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [6:0]      own_addr,
    input  logic            cfg_pec_req,
    input  logic [NFLT-1:0] fault_in,
    input  logic            ev_start,
    input  logic            ev_stop,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            tx_take,
    input  logic            arb_lost,
    output logic            ack,
    output logic            ack_vld,
    output logic [7:0]      tx_byte,
    output logic            wr_stb,
    output logic [7:0]      wr_cmd,
    output logic [7:0]      wr_data,
    output logic            store_req,
    output logic            alert
);
    localparam int PADW = 7 - NFLT;

    smbt_state_e st, st_nx;
    logic [7:0]  cmd_q, dat_q, tx_q, crc;
    logic        pec_bad;
    logic        own_w, own_r, ara_r;
    logic        cml, cml_set, cml_clr, ara_done, wr_ok, ack_d;
    logic [7:0]  status_b;

    smbt_addr_dec u_dec (
        .addr_byte (rx_byte),
        .own_addr  (own_addr),
        .alert     (alert),
        .own_w     (own_w),
        .own_r     (own_r),
        .ara_r     (ara_r)
    );

    smbt_pec_acc u_pec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ev_start),
        .en    ((rx_valid | tx_take) & ~ev_start),
        .din   (rx_valid ? rx_byte : tx_q),
        .crc   (crc)
    );

    smbt_alert_ctrl #(.NFLT(NFLT)) u_alert (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_in (fault_in),
        .cml_set  (cml_set),
        .cml_clr  (cml_clr),
        .ara_done (ara_done),
        .alert    (alert),
        .cml      (cml)
    );

    function automatic logic is_send_byte(input logic [7:0] c);
        return (c == STORE_CMD) || (c == CLR_CMD);
    endfunction

    always_comb begin
        status_b = {{PADW{1'b0}}, fault_in, cml};
        wr_ok    = ev_stop && !ev_start &&
                   ((st == ST_PEC && !cfg_pec_req) || (st == ST_CHK && !pec_bad));
        cml_set  = ev_stop && !ev_start &&
                   ((st == ST_PEC && cfg_pec_req) || (st == ST_CHK && pec_bad));
        cml_clr  = wr_ok && (cmd_q == CLR_CMD);
        ara_done = (st == ST_ARA) && tx_take && !arb_lost && !ev_start && !ev_stop;
        unique case (st)
            ST_ADDR:                 ack_d = own_w | own_r | ara_r;
            ST_CMD, ST_DATA, ST_PEC: ack_d = 1'b1;
            default:                 ack_d = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        if (ev_start) begin
            st_nx = ST_ADDR;
        end else if (ev_stop) begin
            st_nx = ST_IDLE;
        end else if (rx_valid) begin
            unique case (st)
                ST_ADDR: begin
                    if (own_w)      st_nx = ST_CMD;
                    else if (own_r) st_nx = ST_RD;
                    else if (ara_r) st_nx = ST_ARA;
                    else            st_nx = ST_SKIP;
                end
                ST_CMD:  st_nx = is_send_byte(rx_byte) ? ST_PEC : ST_DATA;
                ST_DATA: st_nx = ST_PEC;
                ST_PEC:  st_nx = ST_CHK;
                default: st_nx = st;
            endcase
        end else if (tx_take) begin
            unique case (st)
                ST_RD:   st_nx = ST_RPEC;
                ST_ARA:  st_nx = arb_lost ? ST_SKIP : ST_RPEC;
                ST_RPEC: st_nx = ST_SKIP;
                default: st_nx = st;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= 8'h00;
            dat_q     <= 8'h00;
            pec_bad   <= 1'b0;
            tx_q      <= 8'hFF;
            ack       <= 1'b0;
            ack_vld   <= 1'b0;
            wr_stb    <= 1'b0;
            wr_cmd    <= 8'h00;
            wr_data   <= 8'h00;
            store_req <= 1'b0;
        end else begin
            ack_vld   <= rx_valid && !ev_start && !ev_stop;
            ack       <= rx_valid && !ev_start && !ev_stop && ack_d;
            wr_stb    <= wr_ok;
            store_req <= wr_ok && (cmd_q == STORE_CMD);
            if (wr_ok) begin
                wr_cmd  <= cmd_q;
                wr_data <= dat_q;
            end
            if (ev_start) begin
                pec_bad <= 1'b0;
                tx_q    <= 8'hFF;
            end else if (ev_stop) begin
                tx_q    <= 8'hFF;
            end else if (rx_valid) begin
                unique case (st)
                    ST_ADDR: begin
                        if (own_r)      tx_q <= status_b;
                        else if (ara_r) tx_q <= {own_addr, 1'b0};
                        else            tx_q <= 8'hFF;
                    end
                    ST_CMD: begin
                        cmd_q <= rx_byte;
                        dat_q <= 8'h00;
                    end
                    ST_DATA: dat_q   <= rx_byte;
                    ST_PEC:  pec_bad <= (rx_byte != crc);
                    ST_CHK:  pec_bad <= 1'b1;
                    default: ;
                endcase
            end else if (tx_take) begin
                unique case (st)
                    ST_RD:   tx_q <= crc8_step(crc, tx_q);
                    ST_ARA:  tx_q <= arb_lost ? 8'hFF : crc8_step(crc, tx_q);
                    default: tx_q <= 8'hFF;
                endcase
            end
        end
    end

    always_comb tx_byte = tx_q;

    p_commit_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(ev_stop));

    p_store_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> (wr_stb && wr_cmd == STORE_CMD));

    p_req_pec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && st == ST_PEC && cfg_pec_req) |=> !wr_stb);

    p_no_ack_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev_start && !ev_stop && st == ST_SKIP) |=> (ack_vld && !ack));

    p_no_ack_after_pec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev_start && !ev_stop && st == ST_CHK) |=> !ack);

    p_lost_ff_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP && !ev_start) |-> (tx_byte == 8'hFF));
endmodule

// File: tb/sim_smbus_pec_target.sv
module sim_smbus_pec_target;
    localparam int NFLT = 4;
    localparam logic [6:0] OWN = 7'h24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_pec_req = 1'b0;
    logic [NFLT-1:0] fault_in = '0;
    logic ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0, tx_take = 1'b0, arb_lost = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic ack, ack_vld, wr_stb, store_req, alert;
    logic [7:0] tx_byte, wr_cmd, wr_data;

    int checks = 0;
    int errors = 0;
    bit exp_cml = 1'b0;
    bit exp_alert = 1'b0;

    always #4 clk = ~clk;

    smbus_pec_target #(.NFLT(NFLT)) u0 (
        .clk(clk), .rst_n(rst_n), .own_addr(OWN), .cfg_pec_req(cfg_pec_req),
        .fault_in(fault_in), .ev_start(ev_start), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_take(tx_take), .arb_lost(arb_lost),
        .ack(ack), .ack_vld(ack_vld), .tx_byte(tx_byte), .wr_stb(wr_stb),
        .wr_cmd(wr_cmd), .wr_data(wr_data), .store_req(store_req), .alert(alert)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    function automatic bit send_only(input logic [7:0] c);
        return (c == 8'h03) || (c == 8'h15);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic a);
        @(negedge clk); rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        a = ack & ack_vld;
    endtask

    task automatic take(input logic lost);
        @(negedge clk); tx_take = 1'b1; arb_lost = lost;
        @(negedge clk); tx_take = 1'b0; arb_lost = 1'b0;
    endtask

    // mode: 0 no PEC, 1 good PEC, 2 bad PEC, 3 good PEC plus extra byte
    task automatic do_write(input logic [7:0] cmd, input logic [7:0] dat, input int mode);
        logic a;
        logic [7:0] c;
        logic [7:0] pec;
        bit commit;
        do_start();
        send({OWN, 1'b0}, a); chk(a == 1'b1, "R1 own write addr ack", a, 1);
        c = ref_crc(8'h00, {OWN, 1'b0});
        send(cmd, a); chk(a == 1'b1, "R1 cmd ack", a, 1);
        c = ref_crc(c, cmd);
        if (!send_only(cmd)) begin
            send(dat, a);
            c = ref_crc(c, dat);
        end
        if (mode != 0) begin
            pec = (mode == 2) ? (c ^ 8'h5A) : c;
            send(pec, a);
        end
        if (mode == 3) begin
            send(8'h33, a); chk(a == 1'b0, "R4 byte after PEC nack", a, 0);
        end
        commit = (mode == 0 && !cfg_pec_req) || (mode == 1);
        do_stop();
        chk(wr_stb == commit, "R2 R3 R4 R5 commit decision", wr_stb, commit);
        if (commit) begin
            chk(wr_cmd == cmd, "R6 wr_cmd", wr_cmd, cmd);
            chk(wr_data == (send_only(cmd) ? 8'h00 : dat), "R6 wr_data", wr_data,
                send_only(cmd) ? 8'h00 : dat);
            chk(store_req == (cmd == 8'h15), "R7 store_req", store_req, cmd == 8'h15);
            if (cmd == 8'h03) exp_cml = 1'b0;
        end else begin
            exp_cml = 1'b1;
            exp_alert = 1'b1;
        end
        chk(alert == exp_alert, "R4 R12 alert after write", alert, exp_alert);
    endtask

    task automatic read_status();
        logic a;
        logic [7:0] st;
        do_start();
        send({OWN, 1'b1}, a); chk(a == 1'b1, "R1 own read ack", a, 1);
        st = {3'b000, fault_in, exp_cml};
        chk(tx_byte == st, "R8 status byte", tx_byte, st);
        take(1'b0);
        chk(tx_byte == ref_crc(ref_crc(8'h00, {OWN, 1'b1}), st), "R8 read PEC", tx_byte,
            ref_crc(ref_crc(8'h00, {OWN, 1'b1}), st));
        take(1'b0);
        do_stop();
    endtask

    task automatic do_ara(input logic lost, input bit exp_back);
        logic a;
        do_start();
        send(8'h19, a); chk(a == 1'b1, "R1 alert response ack", a, 1);
        chk(tx_byte == {OWN, 1'b0}, "R9 own address returned", tx_byte, {OWN, 1'b0});
        take(lost);
        if (lost) begin
            chk(alert == 1'b1, "R11 alert kept after lost arbitration", alert, 1);
            chk(tx_byte == 8'hFF, "R11 idle byte after loss", tx_byte, 8'hFF);
        end else begin
            chk(alert == 1'b0, "R9 alert released", alert, 0);
            chk(tx_byte == ref_crc(ref_crc(8'h00, 8'h19), {OWN, 1'b0}), "R9 response PEC",
                tx_byte, ref_crc(ref_crc(8'h00, 8'h19), {OWN, 1'b0}));
            @(negedge clk);
            chk(alert == exp_back, "R10 alert after release", alert, exp_back);
            exp_alert = exp_back;
        end
        do_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        void'($urandom(32'd20211));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(alert == 1'b0, "R12 reset alert", alert, 0);
        chk(wr_stb == 1'b0, "R6 reset wr_stb", wr_stb, 0);
        chk(tx_byte == 8'hFF, "R8 reset tx_byte", tx_byte, 8'hFF);

        // status read with no faults
        read_status();

        // ARA while alert low must not be acknowledged
        do_start();
        send(8'h19, a); chk(a == 1'b0, "R1 ARA nack without alert", a, 0);
        do_stop();

        // other address ignored
        do_start();
        send({7'h11, 1'b0}, a); chk(a == 1'b0, "R1 foreign addr nack", a, 0);
        send(8'h40, a); chk(a == 1'b0, "R1 later byte nack", a, 0);
        do_stop();
        chk(wr_stb == 1'b0, "R1 foreign write no commit", wr_stb, 0);

        // directed PEC cases
        do_write(8'h21, 8'hA5, 0);
        do_write(8'h22, 8'h5C, 1);
        do_write(8'h15, 8'h00, 1);
        do_write(8'h23, 8'h01, 2);
        read_status();
        do_write(8'h24, 8'h02, 3);

        // incomplete write and repeated START: discarded silently
        do_start();
        send({OWN, 1'b0}, a); send(8'h30, a);
        do_stop();
        chk(wr_stb == 1'b0, "R6 truncated write no commit", wr_stb, 0);
        do_start();
        send({OWN, 1'b0}, a); send(8'h30, a); send(8'h77, a);
        do_start();
        do_stop();
        chk(wr_stb == 1'b0, "R6 restart discards", wr_stb, 0);

        // only the communication fault pending: no re-raise
        do_ara(1'b0, 1'b0);
        do_write(8'h03, 8'h00, 0);
        read_status();

        // persistent fault: raise, answer, re-raise
        @(negedge clk); fault_in = 4'b0100;
        @(negedge clk);
        chk(alert == 1'b1, "R12 fault rise sets alert", alert, 1);
        exp_alert = 1'b1;
        read_status();
        do_ara(1'b0, 1'b1);
        do_ara(1'b1, 1'b1);
        @(negedge clk); fault_in = 4'b0000;
        do_ara(1'b0, 1'b0);

        // required-PEC mode
        cfg_pec_req = 1'b1;
        do_write(8'h40, 8'h99, 0);
        do_write(8'h41, 8'h98, 1);

        // randomized writes
        for (int n = 0; n < 60; n++) begin
            logic [7:0] cmd;
            cfg_pec_req = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) cmd = ($urandom_range(0, 1) != 0) ? 8'h15 : 8'h03;
            else cmd = 8'($urandom_range(0, 255));
            do_write(cmd, 8'($urandom_range(0, 255)), int'($urandom_range(0, 3)));
        end
        cfg_pec_req = 1'b0;
        read_status();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule